// File: doc/BRIEF.md
# I2C Slave Address Recognizer with Acknowledge Control

This block is the listening half of an I2C target port. It samples the raw SCL and SDA lines and passes each through a synchronizer and a glitch filter. From the filtered levels it finds START and STOP conditions, then shifts in the first byte after every START. The top seven bits of that byte are compared with a programmed own address. A general call (address byte 00H) can also be accepted when it is enabled. When the address matches and acknowledge is allowed, the block pulls SDA low for the ninth clock. It raises an interrupt flag with an 8-bit status code and holds SCL low until software clears the flag.

After a write address, data bytes are shifted in and presented on a data register. Each byte is acknowledged or refused according to the acknowledge-enable input, read at the moment the eighth bit completes. Clearing that input during a transfer makes the block refuse the next byte and drop back to listening. The bus is still watched while acknowledge is off, so recognition resumes as soon as the input is set again. A local master that has just lost arbitration signals this on a pulse input. If the block is then addressed, it reports this through distinct status codes.

Top module: `i2c_sar`

## Requirements
- R1: The own address is `own_addr_i[7:1]`. An address byte whose bits 7..1 equal it is acknowledged (SDA pulled low during the ninth SCL pulse) while `ack_en_i` is 1. A write (bit 0 = 0) sets the flag with status 60H. Any other non-general-call address gets no acknowledge and no flag.
- R2: With `own_addr_i[0]` = 1, address byte 00H is acknowledged and flagged with status 70H. With `own_addr_i[0]` = 0 it gets no acknowledge and no flag.
- R3: While `ack_en_i` is 0, no address is acknowledged or flagged. Setting it to 1 makes the next address phase recognized again without any reset.
- R4: Own address with bit 0 = 1 (read) is acknowledged with status A8H and receives no data. Once the flag is cleared, the block returns to listening.
- R5: After a write address, each data byte appears on `rx_data_o` (first bit received = bit 7). It is acknowledged with status 80H, or 90H when the address was the general call.
- R6: If `ack_en_i` is 0 when the eighth bit of a data byte completes, that byte is refused (SDA left high). The status is 88H, or 98H after a general call. SCL is not held, and later bytes are ignored until the next START.
- R7: After a pulse on `arb_lost_i`, the next recognized address reports 68H (own address, write), 78H (general call) or B0H (own address, read) instead of 60H, 70H or A8H.
- R8: After an acknowledged byte's ninth clock, `scl_oe_o` holds SCL low with SDA released until the flag is cleared. It then releases SCL.
- R9: A STOP or repeated START while receiving data sets the flag with status A0H and ends the transfer. A repeated START begins a new address phase.
- R10: `irq_o` stays set until a cycle with `irq_clr_i` = 1. A new event in that same cycle takes priority.
- R11: START and STOP are recognized only from SDA edges while SCL is high, after filtering. A pulse on SDA shorter than FILT_LEN clock cycles has no effect.
- R12: After reset, no line is driven, `irq_o` is 0, `rx_data_o` is 00H and `status_o` is F8H. While the flag is set, `status_o` holds one of the codes listed here.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| own_addr_i | input | 8 | Bits 7..1 own address, bit 0 general-call enable |
| ack_en_i | input | 1 | Acknowledge enable |
| arb_lost_i | input | 1 | Pulse: local master lost arbitration |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| irq_o | output | 1 | Interrupt flag |
| status_o | output | 8 | Status code of the last event |
| rx_data_o | output | 8 | Last received data byte |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a four-cycle filter and general-call support generated in. A filter of four cycles lets a two-cycle SDA dip during a high SCL phase be injected while the block is receiving, which brings glitch rejection into reach as a missing A0H flag. With general call compiled in, both settings of the enable bit are reachable, so the 70H/90H/98H/78H codes and the ignored 00H address are all exercised. Open-drain lines and the bench master's wait for SCL let clock stretching be observed directly at the ports.

// File: rtl/i2c_sar_pkg.sv
package i2c_sar_pkg;

   localparam int BYTE_W   = 8;
   localparam int STATUS_W = 8;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ADDR,
      S_ADDR_ACK,
      S_DATA,
      S_DATA_ACK,
      S_HOLD
   } sar_state_e;

   localparam logic [STATUS_W-1:0] STS_IDLE        = 8'hF8;
   localparam logic [STATUS_W-1:0] STS_OWN_W       = 8'h60;
   localparam logic [STATUS_W-1:0] STS_ARB_OWN_W   = 8'h68;
   localparam logic [STATUS_W-1:0] STS_GC          = 8'h70;
   localparam logic [STATUS_W-1:0] STS_ARB_GC      = 8'h78;
   localparam logic [STATUS_W-1:0] STS_DAT_ACK     = 8'h80;
   localparam logic [STATUS_W-1:0] STS_DAT_NACK    = 8'h88;
   localparam logic [STATUS_W-1:0] STS_GC_DAT_ACK  = 8'h90;
   localparam logic [STATUS_W-1:0] STS_GC_DAT_NACK = 8'h98;
   localparam logic [STATUS_W-1:0] STS_STOP        = 8'hA0;
   localparam logic [STATUS_W-1:0] STS_OWN_R       = 8'hA8;
   localparam logic [STATUS_W-1:0] STS_ARB_OWN_R   = 8'hB0;

   function automatic logic status_legal(input logic [STATUS_W-1:0] s);
      return (s == STS_OWN_W)      || (s == STS_ARB_OWN_W) ||
             (s == STS_GC)         || (s == STS_ARB_GC)    ||
             (s == STS_DAT_ACK)    || (s == STS_DAT_NACK)  ||
             (s == STS_GC_DAT_ACK) || (s == STS_GC_DAT_NACK) ||
             (s == STS_STOP)       || (s == STS_OWN_R)     ||
             (s == STS_ARB_OWN_R);
   endfunction

endpackage

// File: rtl/i2c_sar_filter.sv
module i2c_sar_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4,
   parameter bit IDLE_LVL    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic                   lvl_q;
   logic                   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {SYNC_STAGES{IDLE_LVL}};
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end

   assign synced = sync_q[SYNC_STAGES-1];

   if (FILT_LEN > 1) begin : g_filter
      localparam int CW = $clog2(FILT_LEN);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= IDLE_LVL;
         end else if (synced == lvl_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            cnt_q <= '0;
            lvl_q <= synced;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end else begin : g_bypass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_q <= IDLE_LVL;
         else        lvl_q <= synced;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_LVL;
      else        prev_q <= lvl_q;
   end

   assign lvl_o  = lvl_q;
   assign rise_o = lvl_q & ~prev_q;
   assign fall_o = ~lvl_q & prev_q;

endmodule

// File: rtl/i2c_sar_cond.sv
module i2c_sar_cond (
   input  logic scl_lvl_i,
   input  logic sda_rise_i,
   input  logic sda_fall_i,
   output logic start_o,
   output logic stop_o
);

   // SDA may only move while SCL is low; a move with SCL high is a condition
   assign start_o = sda_fall_i & scl_lvl_i;
   assign stop_o  = sda_rise_i & scl_lvl_i;

endmodule

// File: rtl/i2c_sar_match.sv
module i2c_sar_match #(
   parameter bit GC_EN = 1'b1
) (
   input  logic [7:0] addr_byte_i,
   input  logic [7:0] own_cfg_i,
   output logic       own_hit_o,
   output logic       gc_hit_o
);

   assign own_hit_o = (addr_byte_i[7:1] == own_cfg_i[7:1]);

   if (GC_EN) begin : g_gc
      assign gc_hit_o = own_cfg_i[0] && (addr_byte_i == 8'h00);
   end else begin : g_no_gc
      assign gc_hit_o = 1'b0;
   end

endmodule

// File: rtl/i2c_sar.sv
module i2c_sar
   import i2c_sar_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4,
   parameter bit GC_EN       = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_i,
   input  logic                sda_i,
   output logic                scl_oe_o,
   output logic                sda_oe_o,
   input  logic [BYTE_W-1:0]   own_addr_i,
   input  logic                ack_en_i,
   input  logic                arb_lost_i,
   input  logic                irq_clr_i,
   output logic                irq_o,
   output logic [STATUS_W-1:0] status_o,
   output logic [BYTE_W-1:0]   rx_data_o
);

   localparam int NLINES = 2;
   localparam int LN_SCL = 0;
   localparam int LN_SDA = 1;
   localparam int BCW    = $clog2(BYTE_W + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c_sar: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("i2c_sar: FILT_LEN must be at least 1");
   end

   logic [NLINES-1:0] raw, lvl, rise, fall;
   assign raw = {sda_i, scl_i};

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      i2c_sar_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .FILT_LEN    (FILT_LEN),
         .IDLE_LVL    (1'b1)
      ) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw_i  (raw[g]),
         .lvl_o  (lvl[g]),
         .rise_o (rise[g]),
         .fall_o (fall[g])
      );
   end

   logic start_p, stop_p;
   i2c_sar_cond u_cond (
      .scl_lvl_i  (lvl[LN_SCL]),
      .sda_rise_i (rise[LN_SDA]),
      .sda_fall_i (fall[LN_SDA]),
      .start_o    (start_p),
      .stop_o     (stop_p)
   );

   logic scl_rise, scl_fall;
   assign scl_rise = rise[LN_SCL];
   assign scl_fall = fall[LN_SCL];

   sar_state_e          state_q, next_q;
   logic [BCW-1:0]      bit_cnt_q;
   logic [BYTE_W-1:0]   shreg_q;
   logic [BYTE_W-1:0]   rx_q;
   logic                gc_q, rd_q, ack_q, arb_q, irq_q, sda_oe_q;
   logic [STATUS_W-1:0] status_q, pend_q;

   logic own_hit, gc_hit;
   i2c_sar_match #(.GC_EN(GC_EN)) u_match (
      .addr_byte_i (shreg_q),
      .own_cfg_i   (own_addr_i),
      .own_hit_o   (own_hit),
      .gc_hit_o    (gc_hit)
   );

   logic addressed, byte_done, addr_take;
   logic [STATUS_W-1:0] addr_code, data_code;

   assign addressed = (state_q == S_DATA) || (state_q == S_DATA_ACK);
   assign byte_done = scl_fall && (bit_cnt_q == BCW'(BYTE_W));
   assign addr_take = ack_en_i && (gc_hit || own_hit);

   always_comb begin
      if (gc_hit)          addr_code = arb_q ? STS_ARB_GC    : STS_GC;
      else if (shreg_q[0]) addr_code = arb_q ? STS_ARB_OWN_R : STS_OWN_R;
      else                 addr_code = arb_q ? STS_ARB_OWN_W : STS_OWN_W;
   end

   always_comb begin
      if (gc_q) data_code = ack_en_i ? STS_GC_DAT_ACK : STS_GC_DAT_NACK;
      else      data_code = ack_en_i ? STS_DAT_ACK    : STS_DAT_NACK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         next_q    <= S_IDLE;
         bit_cnt_q <= '0;
         shreg_q   <= '0;
         rx_q      <= '0;
         gc_q      <= 1'b0;
         rd_q      <= 1'b0;
         ack_q     <= 1'b0;
         arb_q     <= 1'b0;
         irq_q     <= 1'b0;
         sda_oe_q  <= 1'b0;
         status_q  <= STS_IDLE;
         pend_q    <= STS_IDLE;
      end else begin
         if (arb_lost_i) arb_q <= 1'b1;
         if (irq_clr_i)  irq_q <= 1'b0;

         if (start_p) begin
            if (addressed) begin
               irq_q    <= 1'b1;
               status_q <= STS_STOP;
            end
            state_q   <= S_ADDR;
            bit_cnt_q <= '0;
            sda_oe_q  <= 1'b0;
         end else if (stop_p) begin
            if (addressed) begin
               irq_q    <= 1'b1;
               status_q <= STS_STOP;
            end
            state_q  <= S_IDLE;
            sda_oe_q <= 1'b0;
         end else begin
            unique case (state_q)
               S_IDLE: begin
               end
               S_ADDR, S_DATA: begin
                  if (scl_rise) begin
                     shreg_q   <= {shreg_q[BYTE_W-2:0], lvl[LN_SDA]};
                     bit_cnt_q <= bit_cnt_q + 1'b1;
                  end else if (byte_done) begin
                     if (state_q == S_ADDR) begin
                        if (addr_take) begin
                           sda_oe_q <= 1'b1;
                           pend_q   <= addr_code;
                           gc_q     <= gc_hit;
                           rd_q     <= shreg_q[0] & ~gc_hit;
                           arb_q    <= 1'b0;
                           state_q  <= S_ADDR_ACK;
                        end else begin
                           state_q  <= S_IDLE;
                        end
                     end else begin
                        sda_oe_q <= ack_en_i;
                        ack_q    <= ack_en_i;
                        rx_q     <= shreg_q;
                        pend_q   <= data_code;
                        state_q  <= S_DATA_ACK;
                     end
                  end
               end
               S_ADDR_ACK: begin
                  if (scl_fall) begin
                     sda_oe_q  <= 1'b0;
                     irq_q     <= 1'b1;
                     status_q  <= pend_q;
                     bit_cnt_q <= '0;
                     next_q    <= rd_q ? S_IDLE : S_DATA;
                     state_q   <= S_HOLD;
                  end
               end
               S_DATA_ACK: begin
                  if (scl_fall) begin
                     sda_oe_q  <= 1'b0;
                     irq_q     <= 1'b1;
                     status_q  <= pend_q;
                     bit_cnt_q <= '0;
                     next_q    <= S_DATA;
                     state_q   <= ack_q ? S_HOLD : S_IDLE;
                  end
               end
               S_HOLD: begin
                  if (!irq_q) state_q <= next_q;
               end
               default: state_q <= S_IDLE;
            endcase
         end
      end
   end

   assign scl_oe_o  = (state_q == S_HOLD) && irq_q;
   assign sda_oe_o  = sda_oe_q;
   assign irq_o     = irq_q;
   assign status_o  = status_q;
   assign rx_data_o = rx_q;

endmodule

// File: rtl/i2c_sar_chk.sv
module i2c_sar_chk
   import i2c_sar_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic                scl_oe_o,
   input logic                sda_oe_o,
   input logic                irq_o,
   input logic                irq_clr_i,
   input logic                ack_en_i,
   input logic [STATUS_W-1:0] status_o
);

   AST_STRETCH_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe_o |-> irq_o); // R8

   AST_SDA_FREE_IN_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
      scl_oe_o |-> !sda_oe_o); // R8

   AST_ACK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> $past(ack_en_i)); // R3

   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !irq_clr_i) |=> irq_o); // R10

   AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> status_legal(status_o)); // R12

endmodule

bind i2c_sar i2c_sar_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_oe_o  (scl_oe_o),
   .sda_oe_o  (sda_oe_o),
   .irq_o     (irq_o),
   .irq_clr_i (irq_clr_i),
   .ack_en_i  (ack_en_i),
   .status_o  (status_o)
);

// File: tb/i2c_sar_test.sv
module i2c_sar_test;

   localparam int Q = 20;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [7:0] own = 8'h55;
   logic       ack_en = 1'b1;
   logic       arb = 1'b0;
   logic       clr = 1'b0;
   logic       scl_oe, sda_oe, irq;
   logic [7:0] status, rx_data;

   wire scl_line = scl_m & ~scl_oe;
   wire sda_line = sda_m & ~sda_oe;

   int  total = 0;
   int  bad = 0;
   bit  glitch_en = 1'b0;
   bit  arb_pend = 1'b0;

   i2c_sar uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .own_addr_i(own),
      .ack_en_i(ack_en), .arb_lost_i(arb), .irq_clr_i(clr),
      .irq_o(irq), .status_o(status), .rx_data_o(rx_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // {hit, status} for an address byte, from R1, R2, R3, R4, R7
   function automatic logic [8:0] addr_expect(input logic [7:0] a, input logic [7:0] o,
                                              input bit en, input bit ap);
      if (!en) return 9'h0;
      if (a == 8'h00 && o[0]) return {1'b1, ap ? 8'h78 : 8'h70};
      if (a[7:1] == o[7:1])   return {1'b1, a[0] ? (ap ? 8'hB0 : 8'hA8) : (ap ? 8'h68 : 8'h60)};
      return 9'h0;
   endfunction

   function automatic logic [7:0] data_expect(input bit gc, input bit ack);
      if (gc) return ack ? 8'h90 : 8'h98;
      return ack ? 8'h80 : 8'h88;
   endfunction

   task automatic qw;
      repeat (Q) @(negedge clk);
   endtask

   task automatic scl_up;
      scl_m = 1'b1;
      while (!scl_line) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; scl_up; qw;
      sda_m = 1'b0; qw;
      scl_m = 1'b0; qw;
   endtask

   task automatic bus_rstart;
      sda_m = 1'b1; qw;
      scl_up; qw;
      sda_m = 1'b0; qw;
      scl_m = 1'b0; qw;
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; qw;
      scl_up; qw;
      sda_m = 1'b1; qw;
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked, output bit held);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; qw;
         scl_up;
         if (glitch_en && i == 7) begin
            repeat (4) @(negedge clk);
            sda_m = 1'b0;
            repeat (2) @(negedge clk);
            sda_m = 1'b1;
         end
         qw;
         scl_m = 1'b0; qw;
      end
      sda_m = 1'b1; qw;
      scl_up;
      repeat (Q/2) @(negedge clk);
      acked = !sda_line;
      repeat (Q/2) @(negedge clk);
      scl_m = 1'b0;
      repeat (2*Q) @(negedge clk);
      held = scl_oe;
   endtask

   task automatic clear_flag;
      clr = 1'b1; @(negedge clk);
      clr = 1'b0; @(negedge clk);
   endtask

   task automatic pulse_arb;
      arb = 1'b1; @(negedge clk);
      arb = 1'b0; @(negedge clk);
      arb_pend = 1'b1;
   endtask

   // full transfer: START, address, nbytes data (random enable per byte), STOP
   task automatic run_xfer(input logic [7:0] a, input bit en_addr, input int nbytes,
                           input bit rand_nack);
      bit ack, held, addressed, gc, en;
      logic [8:0] e;
      logic [7:0] d;
      ack_en = en_addr;
      bus_start;
      send_byte(a, ack, held);
      e = addr_expect(a, own, en_addr, arb_pend);
      chk("R1 address acknowledge", ack, e[8]);
      chk("R3 address flag", irq, e[8]);
      if (e[8]) begin
         chk("R7 address status", status, e[7:0]);
         chk("R8 stretch after address", held, 1'b1);
         arb_pend = 1'b0;
         clear_flag;
         chk("R8 release after clear", scl_oe, 1'b0);
      end
      addressed = e[8] && !a[0];
      gc = (a == 8'h00);
      ack_en = 1'b1;
      for (int k = 0; k < nbytes; k++) begin
         d = 8'($urandom);
         en = rand_nack ? (($urandom % 4) != 0) : 1'b1;
         ack_en = en;
         send_byte(d, ack, held);
         if (addressed) begin
            chk("R6 data acknowledge", ack, en);
            chk("R5 data flag", irq, 1'b1);
            chk("R5 data status", status, data_expect(gc, en));
            chk("R5 data value", rx_data, d);
            chk("R6 stretch only on ack", held, en);
            clear_flag;
            if (!en) addressed = 1'b0;
         end else begin
            chk("R6 ignored byte ack", ack, 1'b0);
            chk("R6 ignored byte flag", irq, 1'b0);
         end
         ack_en = 1'b1;
      end
      bus_stop;
      chk("R9 stop flag", irq, addressed);
      if (addressed) begin
         chk("R9 stop status", status, 8'hA0);
         clear_flag;
      end
      qw;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      bit ack, held;
      logic [7:0] a, other;
      int pick;
      void'($urandom(32'd1357));
      repeat (5) @(negedge clk);
      // R12 reset state
      chk("R12 reset irq", irq, 1'b0);
      chk("R12 reset sda", sda_oe, 1'b0);
      chk("R12 reset scl", scl_oe, 1'b0);
      chk("R12 reset status", status, 8'hF8);
      chk("R12 reset data", rx_data, 8'h00);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      own = 8'h55;                        // address 2A, general call on
      run_xfer(8'h54, 1'b1, 4, 1'b0);     // R1 R5
      run_xfer(8'h30, 1'b1, 2, 1'b0);     // R1 mismatch
      run_xfer(8'h00, 1'b1, 3, 1'b0);     // R2 general call
      own = 8'h54;
      run_xfer(8'h00, 1'b1, 1, 1'b0);     // R2 general call disabled
      own = 8'h55;
      run_xfer(8'h54, 1'b0, 1, 1'b0);     // R3 disabled
      run_xfer(8'h54, 1'b1, 1, 1'b0);     // R3 resumes

      // R4 read address: acknowledged, then back to listening
      run_xfer(8'h55, 1'b1, 0, 1'b0);
      chk("R4 idle after read", sda_oe, 1'b0);

      // R6 enable dropped mid transfer
      ack_en = 1'b1;
      bus_start;
      send_byte(8'h54, ack, held);
      chk("R1 own write status", status, 8'h60);
      clear_flag;
      ack_en = 1'b0;
      send_byte(8'hC3, ack, held);
      chk("R6 nack data", ack, 1'b0);
      chk("R6 nack status", status, 8'h88);
      chk("R6 no stretch", held, 1'b0);
      clear_flag;
      ack_en = 1'b1;
      send_byte(8'h11, ack, held);
      chk("R6 later byte ignored", ack, 1'b0);
      bus_stop;
      chk("R6 stop after nack no flag", irq, 1'b0);

      // R7 arbitration lost codes
      pulse_arb; run_xfer(8'h54, 1'b1, 1, 1'b0);
      pulse_arb; run_xfer(8'h00, 1'b1, 1, 1'b0);
      pulse_arb; run_xfer(8'h55, 1'b1, 0, 1'b0);

      // R9 repeated start, then new address phase; R10 flag sticky
      bus_start;
      send_byte(8'h54, ack, held);
      clear_flag;
      send_byte(8'h9A, ack, held);
      chk("R5 byte before restart", rx_data, 8'h9A);
      clear_flag;
      bus_rstart;
      chk("R9 restart flag", irq, 1'b1);
      chk("R9 restart status", status, 8'hA0);
      repeat (200) @(negedge clk);
      chk("R10 flag sticky", irq, 1'b1);
      clear_flag;
      chk("R10 flag cleared", irq, 1'b0);
      send_byte(8'h54, ack, held);
      chk("R9 new address acked", ack, 1'b1);
      chk("R9 new address status", status, 8'h60);
      clear_flag;

      // R11 short SDA dip while SCL high is not a START
      glitch_en = 1'b1;
      send_byte(8'hA5, ack, held);
      glitch_en = 1'b0;
      chk("R11 glitch no restart", status, 8'h80);
      chk("R11 glitch byte intact", rx_data, 8'hA5);
      chk("R11 glitch byte acked", ack, 1'b1);
      clear_flag;
      bus_stop;
      chk("R9 stop status", status, 8'hA0);
      clear_flag;

      // constrained random transfers
      for (int t = 0; t < 24; t++) begin
         own = {7'h2A, 1'($urandom)};
         pick = int'($urandom % 4);
         other = 8'($urandom);
         if (other[7:1] == 7'h2A || other[7:1] == 7'h00) other = 8'h3C;
         case (pick)
            0: a = 8'h54;
            1: a = 8'h55;
            2: a = 8'h00;
            default: a = other;
         endcase
         if (($urandom % 5) == 0) pulse_arb;
         run_xfer(a, (($urandom % 6) != 0), a[0] ? 0 : int'($urandom % 3) + 1, 1'b1);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule